// File: doc/BRIEF.md
# PWM Time-Base Counter With Phase Synchronization

This block is the time base of one PWM channel. An up-counter advances on a clock enable produced by a programmable divider of the system clock. It runs from 0 up to a programmed period and then returns to 0. A compare value turns the counter into a simple PWM waveform. The PWM output is high while the count is below the compare value.

The block can be slaved to another time base. A synchronization event is either a rising edge on the sync input or a one-cycle software force strobe; the two are ORed and behave identically. When phase loading is enabled, the event is remembered. The programmed phase is then copied into the counter on the first time-base tick that follows. A sync output, selectable between pass-through of events, a pulse at counter zero, or off, lets several instances be wired in a chain. Each output feeds the next input, and the first input comes from an external source.

With the divider at 1, a master's zero pulse reaches a slave's counter two system clocks after the master reached zero. With a larger divider the slave loads within one time-base period.

Top module: `pwm_timebase`

## Requirements
- R1: While `rst` is high, `tb_count` is 0 and `sync_out` is 0, and `pwm_out` reflects a count of 0.
- R2: With `cfg_prescale` = P, the counter changes once every P+1 system clocks. It goes from its value c to c+1, or to 0 when c is greater than or equal to `cfg_period`. With P = 0 it changes on every clock, starting at the first edge after reset is released.
- R3: With `cfg_phase_en` = 1 and P = 0, a sync event sampled at clock edge k loads `cfg_phase` into the counter at edge k+1. At edge k itself the counter still advances normally, and counting resumes from the phase value afterwards.
- R4: With P > 0, a sync event sampled at edge k loads the phase at the first tick edge strictly after k. An event sampled on a tick edge is therefore applied one full time-base period later. The count does not move between ticks.
- R5: With `cfg_phase_en` = 0, sync-input edges and force strobes have no effect on the count, and no stale event is applied once phase loading is enabled again.
- R6: A one-cycle high on `sw_force_sync` is a sync event with the same effect and timing as a rising edge on `sync_in`.
- R7: When a phase load and a period wrap fall on the same tick, the counter takes the phase value, not 0.
- R8: With `cfg_sync_mode` = 2'b00 (pass), `sync_out` is high for exactly the one clock after the edge at which a sync event (input rising edge or force) is sampled.
- R9: With `cfg_sync_mode` = 2'b01 (zero), `sync_out` is high for the one clock after each tick at which the counter becomes 0. It is a single system clock wide even when the count stays at 0 for several clocks.
- R10: With `cfg_sync_mode` = 2'b10 or 2'b11 (off), `sync_out` stays 0.
- R11: `pwm_out` is 1 when `tb_count` < `cfg_compare` and 0 otherwise. A compare of 0 gives a constant 0, and a compare above the period gives a constant 1.
- R12: The sync input is edge sensitive. A level held high for many clocks produces a single event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_period | input | CNT_W | Highest count before wrapping to 0 |
| cfg_phase | input | CNT_W | Value loaded into the counter on a sync event |
| cfg_compare | input | CNT_W | PWM compare threshold |
| cfg_phase_en | input | 1 | 1 = sync events load the phase, 0 = events ignored |
| cfg_prescale | input | PSC_W | Time-base divider minus one |
| cfg_sync_mode | input | 2 | Sync output source: 00 pass, 01 zero, 1x off |
| sw_force_sync | input | 1 | Software force strobe, one clock per write of 1 |
| sync_in | input | 1 | Sync input from the previous stage (edge sensitive) |
| sync_out | output | 1 | Sync output to the next stage |
| tb_count | output | CNT_W | Current time-base count |
| pwm_out | output | 1 | Compare-based PWM output |

## Verification
All inputs are driven and all outputs sampled on the falling clock edge, so a result due "n edges after a stimulus" is read after exactly n falling-edge steps. Counting and phase loads at divider 1 are checked one and two steps after the event: the first step shows the normal increment and the second shows the phase value. Sync-output pulses are checked one step after their cause and again one step later to confirm the single-clock width. For divided time bases, the bench first locks onto a tick by waiting for the count to change, and from then on knows every later tick edge. It places events both just after and exactly on a tick edge, and checks that the count is stable up to the expected load step and holds the phase at it.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;

    // Sync output source selection (bit 1 set means disabled)
    typedef enum logic [1:0] {
        SYNCSEL_PASS = 2'b00,
        SYNCSEL_ZERO = 2'b01,
        SYNCSEL_OFF  = 2'b10
    } sync_sel_e;

    // Pick the sync output pulse for the selected source
    function automatic logic sync_out_pick(input logic [1:0] sel,
                                           input logic       evt,
                                           input logic       zero_hit);
        logic r;
        if (sel[1])                       r = 1'b0;
        else if (sel == SYNCSEL_PASS)     r = evt;
        else                              r = zero_hit;
        return r;
    endfunction

endpackage

// File: rtl/pwmtb_prescaler.sv
module pwmtb_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PSC_W-1:0] div_m1,
    output logic             tick
);
    logic [PSC_W-1:0] acc;

    // Tick once every div_m1+1 clocks; a lowered divider ticks at once
    assign tick = (acc >= div_m1);

    always_ff @(posedge clk) begin
        if (rst)       acc <= '0;
        else if (tick) acc <= '0;
        else           acc <= acc + 1'b1;
    end
endmodule

// File: rtl/pwmtb_sync_front.sv
module pwmtb_sync_front (
    input  logic clk,
    input  logic rst,
    input  logic sync_in,
    input  logic force_sync,
    input  logic phase_en,
    input  logic tick,
    output logic sync_event,
    output logic pend,
    output logic load
);
    logic sync_q;

    // Hardware edge and software strobe merged into one event
    assign sync_event = (sync_in & ~sync_q) | force_sync;
    // Applied only on a tick, and only while loading is enabled
    assign load       = pend & tick & phase_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 1'b0;
            pend   <= 1'b0;
        end else begin
            sync_q <= sync_in;
            if (!phase_en) pend <= 1'b0;
            else           pend <= sync_event | (pend & ~tick);
        end
    end
endmodule

// File: rtl/pwmtb_counter.sv
module pwmtb_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] phase,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             zero_hit
);
    logic [CNT_W-1:0] nxt;

    // Load wins over wrap; >= keeps a shrunk period from overrunning
    always_comb begin
        if (load)                 nxt = phase;
        else if (count >= period) nxt = '0;
        else                      nxt = count + 1'b1;
    end

    assign zero_hit = tick & (nxt == '0);

    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (tick) count <= nxt;
    end
endmodule

// File: rtl/pwmtb_sync_out.sv
module pwmtb_sync_out
    import pwm_tb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] sel,
    input  logic       sync_event,
    input  logic       zero_hit,
    output logic       sync_out
);
    always_ff @(posedge clk) begin
        if (rst) sync_out <= 1'b0;
        else     sync_out <= sync_out_pick(sel, sync_event, zero_hit);
    end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int CNT_W = 16,
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_phase,
    input  logic [CNT_W-1:0] cfg_compare,
    input  logic             cfg_phase_en,
    input  logic [PSC_W-1:0] cfg_prescale,
    input  logic [1:0]       cfg_sync_mode,
    input  logic             sw_force_sync,
    input  logic             sync_in,
    output logic             sync_out,
    output logic [CNT_W-1:0] tb_count,
    output logic             pwm_out
);
    logic tick;
    logic sync_event;
    logic pend;
    logic load;
    logic zero_hit;

    pwmtb_prescaler #(.PSC_W(PSC_W)) psc_i (
        .clk    (clk),
        .rst    (rst),
        .div_m1 (cfg_prescale),
        .tick   (tick)
    );

    pwmtb_sync_front front_i (
        .clk        (clk),
        .rst        (rst),
        .sync_in    (sync_in),
        .force_sync (sw_force_sync),
        .phase_en   (cfg_phase_en),
        .tick       (tick),
        .sync_event (sync_event),
        .pend       (pend),
        .load       (load)
    );

    pwmtb_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (load),
        .phase    (cfg_phase),
        .period   (cfg_period),
        .count    (tb_count),
        .zero_hit (zero_hit)
    );

    pwmtb_sync_out so_i (
        .clk        (clk),
        .rst        (rst),
        .sel        (cfg_sync_mode),
        .sync_event (sync_event),
        .zero_hit   (zero_hit),
        .sync_out   (sync_out)
    );

    // Compare stage
    assign pwm_out = (tb_count < cfg_compare);
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             pend,
    input logic             phase_en,
    input logic             sync_event,
    input logic [1:0]       mode,
    input logic             sync_out,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] phase,
    input logic [CNT_W-1:0] period
);
    // R2: the count only moves on a divider tick
    a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count));

    // R3: a pending event on a tick puts the phase in the counter
    a_r3_phase_load: assert property (@(posedge clk) disable iff (rst)
        (tick && pend && phase_en) |=> (count == $past(phase)));

    // R7: load at the wrap point still yields the phase value
    a_r7_load_over_wrap: assert property (@(posedge clk) disable iff (rst)
        (tick && pend && phase_en && (count >= period)) |=> (count == $past(phase)));

    // R5: nothing stays pending while loading is disabled
    a_r5_no_pending_when_off: assert property (@(posedge clk) disable iff (rst)
        !phase_en |=> !pend);

    // R8: pass mode echoes an event on the next clock
    a_r8_pass_echo: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00 && sync_event) |=> sync_out);

    // R10: off modes keep the output low
    a_r10_off_quiet: assert property (@(posedge clk) disable iff (rst)
        mode[1] |=> !sync_out);
endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .pend       (pend),
    .phase_en   (cfg_phase_en),
    .sync_event (sync_event),
    .mode       (cfg_sync_mode),
    .sync_out   (sync_out),
    .count      (tb_count),
    .phase      (cfg_phase),
    .period     (cfg_period)
);

// File: tb/pwm_timebase_tb_top.sv
module pwm_timebase_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 16;
    localparam int PSC_W = 8;
    localparam int WATCHDOG = 20000;

    logic             clk = 1'b0;
    logic             rst;
    logic [CNT_W-1:0] cfg_period;
    logic [CNT_W-1:0] cfg_phase;
    logic [CNT_W-1:0] cfg_compare;
    logic             cfg_phase_en;
    logic [PSC_W-1:0] cfg_prescale;
    logic [1:0]       cfg_sync_mode;
    logic             sw_force_sync;
    logic             sync_in;
    logic             sync_out;
    logic [CNT_W-1:0] tb_count;
    logic             pwm_out;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .cfg_period    (cfg_period),
        .cfg_phase     (cfg_phase),
        .cfg_compare   (cfg_compare),
        .cfg_phase_en  (cfg_phase_en),
        .cfg_prescale  (cfg_prescale),
        .cfg_sync_mode (cfg_sync_mode),
        .sw_force_sync (sw_force_sync),
        .sync_in       (sync_in),
        .sync_out      (sync_out),
        .tb_count      (tb_count),
        .pwm_out       (pwm_out)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int nx(input int c, input int per);
        return (c >= per) ? 0 : c + 1;
    endfunction

    // Step until the count changes; leaves the bench just after a tick edge
    task automatic lock_tick();
        int prev;
        prev = int'(tb_count);
        for (int i = 0; i < 12; i++) begin
            step(1);
            if (int'(tb_count) != prev) break;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; cfg_period = 9; cfg_phase = 0; cfg_compare = 4;
        cfg_phase_en = 1'b0; cfg_prescale = 0; cfg_sync_mode = 2'b10;
        sw_force_sync = 1'b0; sync_in = 1'b0;
        step(4);
        chk("R1 count in reset", int'(tb_count), 0);
        chk("R1 sync_out in reset", int'(sync_out), 0);
        chk("R1 pwm in reset", int'(pwm_out), 1);
    endtask

    task automatic t_count();
        int c = 0;
        rst = 1'b0;
        for (int i = 0; i < 25; i++) begin
            step(1);
            c = nx(c, 9);
            chk("R2 count sequence", int'(tb_count), c);
            chk("R11 pwm vs compare", int'(pwm_out), (c < 4) ? 1 : 0);
        end
    endtask

    task automatic t_pwm_edges();
        cfg_compare = 0;
        for (int i = 0; i < 10; i++) begin
            step(1);
            chk("R11 compare zero", int'(pwm_out), 0);
        end
        cfg_compare = 20;
        for (int i = 0; i < 10; i++) begin
            step(1);
            chk("R11 compare above period", int'(pwm_out), 1);
        end
        cfg_compare = 4;
    endtask

    task automatic t_prescale();
        int c;
        cfg_prescale = 2;
        lock_tick();
        c = int'(tb_count);
        for (int k = 0; k < 4; k++) begin
            step(1); chk("R2 hold between ticks", int'(tb_count), c);
            step(1); chk("R2 hold between ticks", int'(tb_count), c);
            step(1); c = nx(c, 9);
            chk("R2 divided advance", int'(tb_count), c);
        end
        cfg_prescale = 0;
        step(1);
    endtask

    task automatic t_sync_p0();
        int c;
        cfg_period = 40; cfg_phase = 30; cfg_phase_en = 1'b1;
        step(2);
        c = int'(tb_count);
        sync_in = 1'b1;
        step(1);
        chk("R3 no load on sampling edge", int'(tb_count), nx(c, 40));
        sync_in = 1'b0;
        step(1);
        chk("R3 phase loaded next edge", int'(tb_count), 30);
        step(1);
        chk("R3 counting resumes from phase", int'(tb_count), 31);
    endtask

    task automatic t_sync_div();
        int c;
        cfg_prescale = 3; cfg_phase = 25;
        lock_tick();
        c = int'(tb_count);
        sync_in = 1'b1;
        step(1);
        sync_in = 1'b0;
        chk("R4 no load before tick", int'(tb_count), c);
        step(1); chk("R4 no load before tick", int'(tb_count), c);
        step(1); chk("R4 no load before tick", int'(tb_count), c);
        step(1); chk("R4 load on next tick", int'(tb_count), 25);
        // event sampled exactly on a tick edge
        step(3);
        sync_in = 1'b1;
        step(1);
        sync_in = 1'b0;
        chk("R4 event on tick edge not applied there", int'(tb_count), 26);
        step(1); chk("R4 hold until following tick", int'(tb_count), 26);
        step(1); chk("R4 hold until following tick", int'(tb_count), 26);
        step(1); chk("R4 hold until following tick", int'(tb_count), 26);
        step(1); chk("R4 load one period later", int'(tb_count), 25);
        cfg_prescale = 0;
        step(1);
    endtask

    task automatic t_disable();
        int c;
        cfg_phase_en = 1'b0; cfg_phase = 2;
        step(1);
        c = int'(tb_count);
        sync_in = 1'b1;
        step(1); c = nx(c, 40);
        chk("R5 sync ignored", int'(tb_count), c);
        sync_in = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step(1); c = nx(c, 40);
            chk("R5 sync ignored", int'(tb_count), c);
        end
        sw_force_sync = 1'b1;
        step(1); c = nx(c, 40);
        sw_force_sync = 1'b0;
        chk("R5 force ignored", int'(tb_count), c);
        step(1); c = nx(c, 40);
        chk("R5 force ignored", int'(tb_count), c);
        cfg_phase_en = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step(1); c = nx(c, 40);
            chk("R5 no stale load after enable", int'(tb_count), c);
        end
    endtask

    task automatic t_force();
        int c;
        cfg_phase = 12;
        c = int'(tb_count);
        sw_force_sync = 1'b1;
        step(1);
        sw_force_sync = 1'b0;
        chk("R6 force timing like input", int'(tb_count), nx(c, 40));
        step(1); chk("R6 force loads phase", int'(tb_count), 12);
        step(1); chk("R6 counting after force", int'(tb_count), 13);
    endtask

    task automatic t_wrap();
        cfg_period = 12; cfg_phase = 5;
        for (int i = 0; i < 40; i++) begin
            if (int'(tb_count) == 11) break;
            step(1);
        end
        sync_in = 1'b1;
        step(1);
        sync_in = 1'b0;
        chk("R7 reaches period", int'(tb_count), 12);
        step(1); chk("R7 load beats wrap", int'(tb_count), 5);
    endtask

    task automatic t_held();
        int c;
        cfg_period = 40; cfg_phase = 3;
        step(1);
        c = int'(tb_count);
        sync_in = 1'b1;
        step(1); chk("R12 held input first edge", int'(tb_count), nx(c, 40));
        step(1); chk("R12 single load", int'(tb_count), 3);
        step(1); chk("R12 no reload while held", int'(tb_count), 4);
        step(1); chk("R12 no reload while held", int'(tb_count), 5);
        sync_in = 1'b0;
        step(1); chk("R12 no reload on release", int'(tb_count), 6);
    endtask

    task automatic t_pass();
        cfg_sync_mode = 2'b00;
        step(1); chk("R8 idle output low", int'(sync_out), 0);
        sync_in = 1'b1;
        step(1);
        sync_in = 1'b0;
        chk("R8 input event passed", int'(sync_out), 1);
        step(1); chk("R8 one clock wide", int'(sync_out), 0);
        sw_force_sync = 1'b1;
        step(1);
        sw_force_sync = 1'b0;
        chk("R8 force event passed", int'(sync_out), 1);
        step(1); chk("R8 one clock wide", int'(sync_out), 0);
    endtask

    task automatic t_zero();
        int c;
        bit found = 0;
        int prev;
        cfg_sync_mode = 2'b01; cfg_phase_en = 1'b0; cfg_period = 7;
        step(2);
        c = int'(tb_count);
        for (int i = 0; i < 16; i++) begin
            step(1); c = nx(c, 7);
            chk("R9 count under zero mode", int'(tb_count), c);
            chk("R9 pulse at zero", int'(sync_out), (c == 0) ? 1 : 0);
        end
        cfg_prescale = 2;
        for (int i = 0; i < 40; i++) begin
            prev = int'(tb_count);
            step(1);
            if (int'(tb_count) == 0 && prev != 0) begin
                found = 1;
                break;
            end
        end
        chk("R9 zero reached with divider", int'(found), 1);
        chk("R9 pulse on zero entry", int'(sync_out), 1);
        step(1); chk("R9 single clock while zero held", int'(sync_out), 0);
        step(1); chk("R9 single clock while zero held", int'(sync_out), 0);
        cfg_prescale = 0;
        step(1);
    endtask

    task automatic t_off();
        cfg_sync_mode = 2'b10; cfg_phase_en = 1'b1; cfg_period = 3; cfg_phase = 0;
        for (int i = 0; i < 20; i++) begin
            sync_in = (i % 4 == 0);
            if (i == 10) cfg_sync_mode = 2'b11;
            step(1);
            if (i > 0) chk("R10 output off", int'(sync_out), 0);
        end
        sync_in = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_err++;
        $display("FAIL watchdog R1..all actual=running expected=finished");
        summary();
    end

    initial begin
        t_reset();
        t_count();
        t_pwm_edges();
        t_prescale();
        t_sync_p0();
        t_sync_div();
        t_disable();
        t_force();
        t_wrap();
        t_held();
        t_pass();
        t_zero();
        t_off();
        summary();
    end
endmodule